// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block sits in core logic beside a PLL that supports run-time phase adjustment. User logic presents a 4-bit counter selector, a direction bit and a 10-bit step count, then pulses `start`. The sequencer takes one phase increment at a time. For each increment it sets up the selector and direction, drives a step pulse of fixed minimum width, releases it, and then waits for the PLL's completion flag before it moves on. All of this runs on the free-running scan clock.

A completion flag that is still high from an earlier adjustment is not taken as completion. After each pulse the controller first needs to see the flag low and only then high again. A programmable window limits each wait. If the window runs out, the sequence aborts with an error pulse. A selector outside the legal range, or a zero step count, ends the request at once and issues no pulse.

Top module: `pll_phase_stepper`

## Requirements
- R1: While reset is asserted and in the first cycles after it is released, `ph_step`, `ph_updown`, `ph_sel`, `busy`, `done`, `err_sel` and `err_timeout` are all 0.
- R2: An accepted request with a legal selector and a count N > 0 produces exactly N pulses on `ph_step`. At every pulse, `ph_sel` and `ph_updown` equal the requested values, already hold them in the cycle before the pulse starts, and do not change while `busy` is high.
- R3: Each step pulse stays high for exactly STEP_CYCLES scan clock cycles (default 2, never fewer than 2).
- R4: After a pulse is released, no further pulse starts until the completion flag has been sampled low and then high. A flag that stays high is not counted as completion.
- R5: The legal selector codes are 0 (all outputs), 1 (feedback counter) and 2 to 11 (output counters 0 to 9 in order). A start with a code from 12 to 15 is rejected: `err_sel` is high for one cycle, the cycle after start; no pulse is issued and `busy` stays low.
- R6: A start with a legal selector and a count of 0 gives a one-cycle `done` in the cycle after start. No pulse is issued and `busy` stays low.
- R7: `busy` rises in the cycle after an accepted start. On normal completion, `busy` falls in the same cycle in which `done` is high for exactly one cycle: the cycle after the clock edge that samples the final completion flag.
- R8: A start while `busy` is high is ignored: the pulse count, selector and direction of the running request are unchanged.
- R9: Each completion wait is limited to T = `timeout_lim` cycles, counted from the edge that releases the pulse. If completion has not been sampled by the T-th edge, `busy` falls on that edge, `err_timeout` is high for one cycle, `done` stays low and no more pulses are issued. T = 0 disables the limit.
- R10: The selector check takes priority over the count check. An illegal selector with a count of 0 raises only `err_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled only while idle |
| req_sel | input | 4 | Requested counter selector |
| req_up | input | 1 | Requested direction (1 = up) |
| req_steps | input | 10 | Number of phase increments |
| timeout_lim | input | 16 | Completion wait limit in cycles, 0 = no limit |
| pll_phase_done | input | 1 | Completion flag from the PLL |
| ph_step | output | 1 | Step pulse to the PLL |
| ph_updown | output | 1 | Direction to the PLL |
| ph_sel | output | 4 | Counter selector to the PLL |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err_sel | output | 1 | One-cycle pulse when a selector is rejected |
| err_timeout | output | 1 | One-cycle pulse when a request aborts on timeout |

## Verification
The assertions assume that the completion flag and the request inputs change only between scan clock edges, so that each edge samples a settled level. They also assume that the flag only moves in response to a pulse. The bench drives every input on the falling edge. Its PLL model lowers and raises the flag only after it has seen a pulse released, with delays set for each request, so every completion or timeout edge can be computed ahead of time. The model can also be told to leave the flag high or low for good, which makes the abort cases reachable while staying inside these assumptions.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int SEL_W       = 4;
  localparam int NUM_OUT_CNT = 10;
  localparam logic [SEL_W-1:0] SEL_ALL_OUT = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_FBK     = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_OUT0    = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_MAX     = SEL_W'(2 + NUM_OUT_CNT - 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_WFALL = 3'd3,
    ST_WRISE = 3'd4
  } pps_state_e;

  function automatic logic sel_legal(input logic [SEL_W-1:0] s);
    return (s <= SEL_MAX);
  endfunction

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
  parameter int STEP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic step,
  output logic last
);
  localparam int EFF_CYC = (STEP_CYCLES < 2) ? 2 : STEP_CYCLES;
  localparam int PW_W    = $clog2(EFF_CYC);
  localparam logic [PW_W-1:0] LAST_IDX = PW_W'(EFF_CYC - 1);

  logic            step_q, step_d;
  logic [PW_W-1:0] cnt_q, cnt_d;

  assign last = step_q && (cnt_q == LAST_IDX);
  assign step = step_q;

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    if (fire) begin
      step_d = 1'b1;
      cnt_d  = '0;
    end else if (step_q) begin
      if (last) step_d = 1'b0;
      else      cnt_d  = cnt_q + PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pps_wait_timer.sv
module pps_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_sat;
  logic            cnt_en;

  assign cnt_sat = &cnt_q;
  assign cnt_en  = clr || (en && !cnt_sat);
  assign expired = en && (limit != '0) && (cnt_q >= (limit - TO_W'(1)));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pps_step_counter.sv
module pps_step_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  assign rem_en = load || dec;
  assign last   = (rem_q == CNT_W'(1));

  always_comb begin
    if (load) rem_d = load_val;
    else      rem_d = rem_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/pll_phase_stepper.sv
module pll_phase_stepper #(
  parameter int CNT_W       = 10,
  parameter int TO_W        = 16,
  parameter int STEP_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [pps_pkg::SEL_W-1:0] req_sel,
  input  logic                     req_up,
  input  logic [CNT_W-1:0]         req_steps,
  input  logic [TO_W-1:0]          timeout_lim,
  input  logic                     pll_phase_done,
  output logic                     ph_step,
  output logic                     ph_updown,
  output logic [pps_pkg::SEL_W-1:0] ph_sel,
  output logic                     busy,
  output logic                     done,
  output logic                     err_sel,
  output logic                     err_timeout
);
  import pps_pkg::*;

  logic rst_sync_n;

  pps_state_e       state_q, state_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             esel_q, esel_d;
  logic             eto_q, eto_d;
  logic [SEL_W-1:0] sel_q;
  logic             up_q;

  logic ld_req;
  logic fire;
  logic tmr_clr;
  logic tmr_en;
  logic cnt_dec;
  logic pulse_last;
  logic step_w;
  logic tmr_exp;
  logic cnt_last;

  pps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pps_pulse_gen #(.STEP_CYCLES(STEP_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (fire),
    .step  (step_w),
    .last  (pulse_last)
  );

  pps_wait_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .limit   (timeout_lim),
    .expired (tmr_exp)
  );

  pps_step_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ld_req),
    .load_val (req_steps),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    esel_d  = 1'b0;
    eto_d   = 1'b0;
    ld_req  = 1'b0;
    fire    = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    cnt_dec = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (!sel_legal(req_sel)) begin
            esel_d = 1'b1;
          end else if (req_steps == '0) begin
            done_d = 1'b1;
          end else begin
            ld_req  = 1'b1;
            busy_d  = 1'b1;
            state_d = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        fire    = 1'b1;
        state_d = ST_PULSE;
      end
      ST_PULSE: begin
        if (pulse_last) begin
          tmr_clr = 1'b1;
          state_d = ST_WFALL;
        end
      end
      ST_WFALL: begin
        tmr_en = 1'b1;
        if (tmr_exp) begin
          eto_d   = 1'b1;
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (!pll_phase_done) begin
          state_d = ST_WRISE;
        end
      end
      ST_WRISE: begin
        tmr_en = 1'b1;
        if (pll_phase_done) begin
          cnt_dec = 1'b1;
          if (cnt_last) begin
            done_d  = 1'b1;
            busy_d  = 1'b0;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SETUP;
          end
        end else if (tmr_exp) begin
          eto_d   = 1'b1;
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        busy_d  = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      esel_q  <= 1'b0;
      eto_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      esel_q  <= esel_d;
      eto_q   <= eto_d;
    end
  end

  // request registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      up_q  <= 1'b0;
    end else if (ld_req) begin
      sel_q <= req_sel;
      up_q  <= req_up;
    end
  end

  assign ph_step     = step_w;
  assign ph_updown   = up_q;
  assign ph_sel      = sel_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign err_sel     = esel_q;
  assign err_timeout = eto_q;

endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ph_step,
  input logic       ph_updown,
  input logic [3:0] ph_sel,
  input logic       busy,
  input logic       done,
  input logic       err_sel,
  input logic       err_timeout
);
  AST_STEP_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_step) |=> ph_step); // R3

  AST_STEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ph_step |-> busy); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ph_sel) && $stable(ph_updown))); // R2

  AST_STEP_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph_step |-> (ph_sel <= 4'd11)); // R5

  AST_ERRSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_sel |-> !busy); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err_timeout)); // R7

  AST_NO_RESTEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_step) |=> !ph_step); // R4

  AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!done && !busy)); // R9
endmodule

bind pll_phase_stepper pps_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ph_step     (ph_step),
  .ph_updown   (ph_updown),
  .ph_sel      (ph_sel),
  .busy        (busy),
  .done        (done),
  .err_sel     (err_sel),
  .err_timeout (err_timeout)
);

// File: tb/pll_phase_stepper_tb.sv
module pll_phase_stepper_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  req_sel;
  logic        req_up;
  logic [9:0]  req_steps;
  logic [15:0] timeout_lim;
  logic        pll_flag;
  logic        ph_step, ph_updown, busy, done, err_sel, err_timeout;
  logic [3:0]  ph_sel;

  pll_phase_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel), .req_up(req_up),
    .req_steps(req_steps), .timeout_lim(timeout_lim), .pll_phase_done(pll_flag),
    .ph_step(ph_step), .ph_updown(ph_updown), .ph_sel(ph_sel), .busy(busy),
    .done(done), .err_sel(err_sel), .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // PLL model configuration
  int fall_dly = 0;
  int rise_dly = 1;
  int pll_mode = 0; // 0 normal, 1 never rises, 2 never falls

  // monitor state
  int m_pulses, m_done, m_esel, m_eto, m_minw, m_maxw, m_post, m_w;
  bit armed, seen_low, prev_step;
  logic [3:0] prev_sel, exp_sel;
  logic prev_up, exp_up;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // output monitor
  initial begin
    prev_step = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_step = 0;
      end else begin
        if (done) m_done++;
        if (err_sel) m_esel++;
        if (err_timeout) m_eto++;
        if (!pll_flag) seen_low = 1;
        else if (seen_low) armed = 1;
        if (ph_step && !prev_step) begin
          m_pulses++;
          chk(armed, "R4 step before fall-rise", 0, 1);
          armed = 0;
          seen_low = 0;
          chk(ph_sel == exp_sel, "R2 sel at step", int'(ph_sel), int'(exp_sel));
          chk(ph_updown == exp_up, "R2 dir at step", int'(ph_updown), int'(exp_up));
          chk(prev_sel == ph_sel && prev_up == ph_updown, "R2 setup before step",
              int'(prev_sel), int'(ph_sel));
          m_w = 1;
        end else if (ph_step) begin
          m_w++;
        end
        if (!ph_step && prev_step) begin
          if (m_w < m_minw) m_minw = m_w;
          if (m_w > m_maxw) m_maxw = m_w;
          m_post = 1;
        end else if (!ph_step && busy) begin
          m_post++;
        end
        prev_step = ph_step;
        prev_sel = ph_sel;
        prev_up = ph_updown;
      end
    end
  end

  // PLL completion flag model
  initial begin
    bit mprev;
    mprev = 0;
    forever begin
      @(negedge clk);
      if (ph_step && !mprev) begin
        while (ph_step) @(negedge clk);
        repeat (fall_dly) @(negedge clk);
        if (pll_mode != 2) pll_flag = 1'b0;
        repeat (rise_dly) @(negedge clk);
        if (pll_mode == 0) pll_flag = 1'b1;
      end
      mprev = ph_step;
    end
  end

  task automatic run_req(input int sel, input int up, input int n, input int fd, input int rd,
                         input int mode, input int lim, input bit poke);
    bit valid, go, tmo;
    int k, exp_p, c;
    valid = (sel <= 11);
    go = valid && (n != 0);
    k = 1 + fd + rd;
    tmo = go && (lim != 0) && (mode != 0 || k > lim);
    exp_p = !go ? 0 : (tmo ? 1 : n);
    exp_sel = 4'(sel);
    exp_up = 1'(up);
    fall_dly = fd; rise_dly = rd; pll_mode = mode;
    pll_flag = 1'b1;
    armed = 1; seen_low = 0;
    m_pulses = 0; m_done = 0; m_esel = 0; m_eto = 0; m_minw = 1000; m_maxw = 0; m_post = 0;
    @(negedge clk);
    req_sel = 4'(sel); req_up = 1'(up); req_steps = 10'(n); timeout_lim = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == go, "R7 busy after start", int'(busy), int'(go));
    chk(done == (valid && n == 0), "R6 done after zero-count start", int'(done), int'(valid && n == 0));
    chk(err_sel == !valid, "R5/R10 err_sel after start", int'(err_sel), int'(!valid));
    c = 0;
    while (busy && c < 20000) begin
      @(negedge clk);
      c++;
      if (poke && c == 3) begin
        start = 1'b1; req_sel = 4'(sel) ^ 4'd1; req_up = !1'(up); req_steps = 10'(n + 3);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(c < 20000, "R7 request ended", c, 0);
    repeat (3) @(negedge clk);
    if (poke) chk(m_pulses == exp_p, "R8 start ignored while busy", m_pulses, exp_p);
    else      chk(m_pulses == exp_p, "R2 pulse count", m_pulses, exp_p);
    chk(m_done == ((valid && !tmo) ? 1 : 0), "R7 done pulses", m_done, (valid && !tmo) ? 1 : 0);
    chk(m_esel == (valid ? 0 : 1), "R5 err_sel pulses", m_esel, valid ? 0 : 1);
    chk(m_eto == (tmo ? 1 : 0), "R9 timeout pulses", m_eto, tmo ? 1 : 0);
    if (exp_p > 0) begin
      chk(m_minw == 2 && m_maxw == 2, "R3 step width", m_minw, 2);
    end
    if (tmo) chk(m_post == lim, "R9 abort cycle", m_post, lim);
    repeat (6 + fd + rd) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_sel = '0; req_up = 1'b0; req_steps = '0;
    timeout_lim = '0; pll_flag = 1'b1;
    m_minw = 1000;
    repeat (3) @(negedge clk);
    chk({ph_step, ph_updown, ph_sel, busy, done, err_sel, err_timeout} == '0,
        "R1 outputs in reset", int'({ph_step, ph_updown, ph_sel, busy, done, err_sel, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({ph_step, ph_updown, ph_sel, busy, done, err_sel, err_timeout} == '0,
        "R1 outputs after reset", int'({ph_step, ph_updown, ph_sel, busy, done, err_sel, err_timeout}), 0);

    // sweep: all selectors, both directions, small counts, varied PLL delays
    for (int s = 0; s < 16; s++)
      for (int u = 0; u < 2; u++)
        for (int n = 0; n < 4; n++)
          run_req(s, u, n, s % 3, 1 + (n % 2) + u, 0, 20, 1'b0);

    // R10: illegal selector with zero count
    run_req(13, 0, 0, 0, 1, 0, 20, 1'b0);
    // R8: start while busy
    run_req(7, 1, 4, 2, 2, 0, 20, 1'b1);
    // R9: flag falls but never rises
    run_req(4, 1, 3, 1, 2, 1, 6, 1'b0);
    // R4/R9: flag never falls, leftover high not taken as completion
    run_req(9, 0, 2, 0, 1, 2, 9, 1'b0);
    // R9 boundary: completion on the last allowed edge, then one edge late
    run_req(2, 1, 2, 0, 3, 0, 4, 1'b0);
    run_req(2, 1, 2, 0, 3, 0, 3, 1'b0);
    // R9: limit 0 disables timeout with a slow PLL
    run_req(11, 0, 2, 10, 20, 0, 0, 1'b0);
    // R2: full-scale count
    run_req(1, 1, 1023, 0, 1, 0, 8, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule